// File: doc/BRIEF.md
# Width-Converting Memory Move Engine

This block copies a programmed number of bytes from a source address to a destination address through a single memory-mapped master port. The read access size and the write access size are set separately to 8, 16 or 32 bits. The engine fills a small lane buffer with one or more reads, then drains it with one or more writes. This lets narrow reads be packed into wide writes, or wide reads be split into narrow writes.

Each side can either step its address after every access or stay on one address. A fixed source suits a FIFO port, and a stepping destination suits RAM. A resume flag makes the next move start where the previous move stopped, and any addresses given with that command are ignored. A command is a one-cycle strobe with its fields. The block answers with a one-cycle `done` pulse, or with a one-cycle `err` pulse when it rejects the command.

Top module: `mmove_engine`

## Requirements
- R1: The size codes are 2'b00 = 1 byte, 2'b01 = 2 bytes and 2'b10 = 4 bytes. `bus_size` carries the code of the current access. An access narrower than 32 bits uses the low bits of `bus_rdata` and `bus_wdata`, and the unused upper write bytes are zero.
- R2: A command with size code 2'b11 on either side is rejected. `err` pulses in the cycle after the command, and the command causes no bus access and no `done`.
- R3: All nine legal size pairs move the data correctly. Byte k of the stream, counted from 0 in read order, leaves in lane (k mod write bytes) of write number (k / write bytes). This is little-endian packing and unpacking.
- R4: When `cmd_rd_inc` is 1, the read address advances by the read size after each read. When it is 0, the read address stays fixed for the whole move.
- R5: When `cmd_wr_inc` is 1, the write address advances by the write size after each write. When it is 0, the write address stays fixed.
- R6: When `cmd_cont` is 1, the move starts from the read and write addresses left by the previous executed move, and the supplied addresses are ignored.
- R7: A length that is not a multiple of the larger of the two access sizes is rejected with `err`, and no bus access takes place.
- R8: A legal command with length 0 pulses `done` in the next cycle, with no bus access and no `err`.
- R9: `bus_req` is held, with the address, direction, size and write data stable, until `bus_ready` is sampled high. A move makes exactly len/read-bytes reads and len/write-bytes writes.
- R10: `done` pulses for one cycle in the cycle after the last write is accepted. In that cycle `busy` and `bus_req` are low.
- R11: A command strobe that arrives while `busy` is high is ignored. It causes no `err` and does not change the move in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_rd_addr | input | AW | Source start address |
| cmd_wr_addr | input | AW | Destination start address |
| cmd_rd_size | input | 2 | Read size code |
| cmd_wr_size | input | 2 | Write size code |
| cmd_rd_inc | input | 1 | Step the read address after each read |
| cmd_wr_inc | input | 1 | Step the write address after each write |
| cmd_cont | input | 1 | Resume from the previous final addresses |
| cmd_len | input | LEN_W | Byte count |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_rdata | input | 32 | Read data, low-aligned, taken when ready |
| bus_ready | input | 1 | Access accepted this cycle |

## Verification
The bench targets lane placement across every size pair. A packing design with a wrong lane offset would scramble or repeat bytes in the destination image, and the bench compares that image byte by byte. Fixed-address and stepping sides are mixed, and every bus address is checked as it is issued. A design that stepped a fixed side would walk away from the FIFO address, and one that kept a stepping side fixed would overwrite one word. Resume chains test that the end addresses carry over. The zero-length, reserved-code, misaligned-length and strobe-while-busy cases catch a design that touches the bus when it must not, or that reacts to a command it should ignore.

// File: rtl/mmove_pkg.sv
package mmove_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NLANE      = DATA_W / 8;
  localparam int unsigned LANE_IDX_W = $clog2(NLANE);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } mv_state_e;

  // bytes per access for a size code; 0 marks the reserved code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/mmove_addr.sv
module mmove_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          cont,
  input  logic [AW-1:0] rd_start,
  input  logic [AW-1:0] wr_start,
  input  logic          rd_inc,
  input  logic          wr_inc,
  input  logic          rd_adv,
  input  logic          wr_adv,
  input  logic [2:0]    rd_step,
  input  logic [2:0]    wr_step,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr
);
  logic rd_inc_q, wr_inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr  <= '0;
      wr_addr  <= '0;
      rd_inc_q <= 1'b0;
      wr_inc_q <= 1'b0;
    end else if (load) begin
      rd_inc_q <= rd_inc;
      wr_inc_q <= wr_inc;
      if (!cont) begin
        rd_addr <= rd_start;
        wr_addr <= wr_start;
      end
    end else begin
      if (rd_adv && rd_inc_q) rd_addr <= rd_addr + AW'(rd_step);
      if (wr_adv && wr_inc_q) wr_addr <= wr_addr + AW'(wr_step);
    end
  end
endmodule

// File: rtl/mmove_pack.sv
module mmove_pack
  import mmove_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_en,
  input  logic [LANE_IDX_W-1:0] ofs,
  input  logic [2:0]            ld_nb,
  input  logic [DATA_W-1:0]     din,
  input  logic [2:0]            dr_nb,
  output logic [DATA_W-1:0]     dout
);
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] lane_d;
  logic [NLANE-1:0]  lane_we;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_IDX_W-1:0] rel;
    logic [LANE_IDX_W-1:0] src;
    assign rel = LANE_IDX_W'(g) - ofs;
    assign src = LANE_IDX_W'(g) + ofs;
    assign lane_we[g]       = load_en && ({1'b0, rel} < ld_nb);
    assign lane_d[g*8 +: 8] = din[{rel, 3'b000} +: 8];
    assign dout[g*8 +: 8]   = (3'(g) < dr_nb) ? buf_q[{src, 3'b000} +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else begin
      for (int i = 0; i < NLANE; i++) begin
        if (lane_we[i]) buf_q[i*8 +: 8] <= lane_d[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/mmove_ctrl.sv
module mmove_ctrl
  import mmove_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_rd_size,
  input  logic [1:0]            cmd_wr_size,
  input  logic [LEN_W-1:0]      cmd_len,
  input  logic                  bus_ready,
  output logic                  busy,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [1:0]            bus_size,
  output logic                  done,
  output logic                  err,
  output logic                  addr_load,
  output logic                  rd_adv,
  output logic                  wr_adv,
  output logic [2:0]            rd_nb,
  output logic [2:0]            wr_nb,
  output logic [LANE_IDX_W-1:0] ofs
);
  mv_state_e        state_q;
  logic [1:0]       rs_q, ws_q;
  logic [2:0]       chunk_q, ofs_q;
  logic [LEN_W-1:0] rem_q;
  logic             done_q, err_q;

  logic [2:0] c_rb, c_wb, c_chunk, rd_nxt, wr_nxt;
  logic       accept, c_bad, c_misfit, c_zero;

  assign c_rb     = size_bytes(cmd_rd_size);
  assign c_wb     = size_bytes(cmd_wr_size);
  assign c_bad    = (c_rb == 3'd0) || (c_wb == 3'd0);
  assign c_chunk  = (c_rb > c_wb) ? c_rb : c_wb;
  assign c_misfit = (cmd_len[1:0] & 2'(c_chunk - 3'd1)) != 2'b00;
  assign c_zero   = (cmd_len == '0);
  assign accept   = (state_q == ST_IDLE) && cmd_valid;

  assign rd_nb  = size_bytes(rs_q);
  assign wr_nb  = size_bytes(ws_q);
  assign rd_nxt = ofs_q + rd_nb;
  assign wr_nxt = ofs_q + wr_nb;

  assign addr_load = accept && !c_bad && !c_misfit && !c_zero;
  assign rd_adv    = (state_q == ST_RD) && bus_ready;
  assign wr_adv    = (state_q == ST_WR) && bus_ready;
  assign ofs       = ofs_q[LANE_IDX_W-1:0];

  assign busy     = (state_q != ST_IDLE);
  assign bus_req  = (state_q != ST_IDLE);
  assign bus_we   = (state_q == ST_WR);
  assign bus_size = (state_q == ST_WR) ? ws_q : rs_q;
  assign done     = done_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rs_q    <= 2'b00;
      ws_q    <= 2'b00;
      chunk_q <= 3'd1;
      ofs_q   <= 3'd0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (c_bad || c_misfit) begin
              err_q <= 1'b1;
            end else if (c_zero) begin
              done_q <= 1'b1;
            end else begin
              rs_q    <= cmd_rd_size;
              ws_q    <= cmd_wr_size;
              chunk_q <= c_chunk;
              rem_q   <= cmd_len;
              ofs_q   <= 3'd0;
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            if (rd_nxt == chunk_q) begin
              ofs_q   <= 3'd0;
              state_q <= ST_WR;
            end else begin
              ofs_q <= rd_nxt;
            end
          end
        end
        ST_WR: begin
          if (bus_ready) begin
            rem_q <= rem_q - LEN_W'(wr_nb);
            if (wr_nxt == chunk_q) begin
              ofs_q <= 3'd0;
              if (rem_q == LEN_W'(wr_nb)) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= ST_RD;
              end
            end else begin
              ofs_q <= wr_nxt;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmove_engine.sv
module mmove_engine
  import mmove_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [AW-1:0]     cmd_rd_addr,
  input  logic [AW-1:0]     cmd_wr_addr,
  input  logic [1:0]        cmd_rd_size,
  input  logic [1:0]        cmd_wr_size,
  input  logic              cmd_rd_inc,
  input  logic              cmd_wr_inc,
  input  logic              cmd_cont,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  logic                  addr_load, rd_adv, wr_adv;
  logic [2:0]            rd_nb, wr_nb;
  logic [LANE_IDX_W-1:0] ofs;
  logic [AW-1:0]         rd_addr, wr_addr;

  mmove_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_rd_size (cmd_rd_size),
    .cmd_wr_size (cmd_wr_size),
    .cmd_len     (cmd_len),
    .bus_ready   (bus_ready),
    .busy        (busy),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_size    (bus_size),
    .done        (done),
    .err         (err),
    .addr_load   (addr_load),
    .rd_adv      (rd_adv),
    .wr_adv      (wr_adv),
    .rd_nb       (rd_nb),
    .wr_nb       (wr_nb),
    .ofs         (ofs)
  );

  mmove_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (addr_load),
    .cont     (cmd_cont),
    .rd_start (cmd_rd_addr),
    .wr_start (cmd_wr_addr),
    .rd_inc   (cmd_rd_inc),
    .wr_inc   (cmd_wr_inc),
    .rd_adv   (rd_adv),
    .wr_adv   (wr_adv),
    .rd_step  (rd_nb),
    .wr_step  (wr_nb),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr)
  );

  mmove_pack u_pack (
    .clk     (clk),
    .rst     (rst),
    .load_en (rd_adv),
    .ofs     (ofs),
    .ld_nb   (rd_nb),
    .din     (bus_rdata),
    .dr_nb   (wr_nb),
    .dout    (bus_wdata)
  );

  assign bus_addr = bus_we ? wr_addr : rd_addr;
endmodule

// File: rtl/mmove_chk.sv
module mmove_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_rd_size,
  input logic [1:0]       cmd_wr_size,
  input logic [LEN_W-1:0] cmd_len,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             bus_req,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [1:0]       bus_size,
  input logic [31:0]      bus_wdata,
  input logic             bus_ready
);
  logic legal;
  assign legal = (cmd_rd_size != 2'b11) && (cmd_wr_size != 2'b11);

  a_r1_size_legal: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_size != 2'b11);

  a_r1_narrow_write_zero: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_size == 2'b00 |-> bus_wdata[31:8] == 24'h0);

  a_r2_reserved_rejected: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !busy && !legal |=> err && !done && !bus_req);

  a_r7_odd_len_rejected: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !busy && legal && cmd_len[0] &&
    (cmd_rd_size != 2'b00 || cmd_wr_size != 2'b00) |=> err && !bus_req);

  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !busy && legal && cmd_len == '0 |=> done && !err && !bus_req);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) &&
    $stable(bus_size) && $stable(bus_wdata));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !bus_req && !err);

  a_r11_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> !err);
endmodule

bind mmove_engine mmove_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_rd_size (cmd_rd_size),
  .cmd_wr_size (cmd_wr_size),
  .cmd_len     (cmd_len),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_size    (bus_size),
  .bus_wdata   (bus_wdata),
  .bus_ready   (bus_ready)
);

// File: tb/mmove_engine_bench.sv
module mmove_engine_bench;
  localparam int AW = 32;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [AW-1:0] cmd_rd_addr = '0, cmd_wr_addr = '0;
  logic [1:0] cmd_rd_size = 2'b00, cmd_wr_size = 2'b00;
  logic cmd_rd_inc = 1'b0, cmd_wr_inc = 1'b0, cmd_cont = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic busy, done, err, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ready = 1'b0;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  // bench-side move state
  logic [7:0] dst [256];
  logic [7:0] expd [256];
  logic [31:0] ex_ra, ex_wa, pa_r, pa_w;
  int g_rb, g_wb, g_ri, g_wi, nrd, nwr;
  logic [1:0] g_rs, g_ws;

  always #10 clk = ~clk;

  mmove_engine #(.AW(AW), .LEN_W(LEN_W)) u_mmove_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rd_addr(cmd_rd_addr),
    .cmd_wr_addr(cmd_wr_addr), .cmd_rd_size(cmd_rd_size), .cmd_wr_size(cmd_wr_size),
    .cmd_rd_inc(cmd_rd_inc), .cmd_wr_inc(cmd_wr_inc), .cmd_cont(cmd_cont),
    .cmd_len(cmd_len), .busy(busy), .done(done), .err(err), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  function automatic logic [7:0] src_byte(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  // memory responder, decides acceptance away from the clock edge
  always @(negedge clk) begin
    if (rst || !bus_req) begin
      bus_ready <= 1'b0;
    end else if (($urandom % 4) != 0) begin
      bus_ready <= 1'b1;
      if (bus_we) begin
        check(bus_addr == ex_wa, "R5", "write address", bus_addr, ex_wa);
        check(bus_size == g_ws, "R1", "write size code", bus_size, g_ws);
        for (int k = 0; k < g_wb; k++) dst[8'(bus_addr + 32'(k))] = bus_wdata[k*8 +: 8];
        if (g_wb < 4) check((bus_wdata >> (8 * g_wb)) == 0, "R1", "unused write lanes",
                            bus_wdata, bus_wdata & ((32'h1 << (8 * g_wb)) - 1));
        if (g_wi != 0) ex_wa = ex_wa + 32'(g_wb);
        nwr++;
      end else begin
        check(bus_addr == ex_ra, "R4", "read address", bus_addr, ex_ra);
        check(bus_size == g_rs, "R1", "read size code", bus_size, g_rs);
        bus_rdata <= '0;
        for (int k = 0; k < g_rb; k++) bus_rdata[k*8 +: 8] <= src_byte(8'(bus_addr + 32'(k)));
        if (g_ri != 0) ex_ra = ex_ra + 32'(g_rb);
        nrd++;
      end
    end else begin
      bus_ready <= 1'b0;
    end
  end

  task automatic run_move(input logic [1:0] rs, input logic [1:0] ws, input bit ri,
                          input bit wi, input bit ct, input int len,
                          input logic [31:0] ra, input logic [31:0] wa, input bit inject);
    int rb, wb, chunk, cyc;
    bit reject, seen_done, seen_err;
    logic [31:0] rstart, wstart;
    rb = nbytes(rs); wb = nbytes(ws);
    chunk = (rb > wb) ? rb : wb;
    reject = (rb == 0) || (wb == 0) || ((len % chunk) != 0);
    rstart = ct ? pa_r : ra;
    wstart = ct ? pa_w : wa;
    for (int i = 0; i < 256; i++) begin dst[i] = 8'h00; expd[i] = 8'h00; end
    if (!reject) begin
      for (int k = 0; k < len; k++)
        expd[8'(wstart + 32'(wi ? (k / wb) * wb : 0) + 32'(k % wb))] =
          src_byte(8'(rstart + 32'(ri ? (k / rb) * rb : 0) + 32'(k % rb)));
    end
    g_rs = rs; g_ws = ws; g_rb = rb; g_wb = wb; g_ri = ri; g_wi = wi;
    ex_ra = rstart; ex_wa = wstart; nrd = 0; nwr = 0;
    cmd_rd_addr = ra; cmd_wr_addr = wa; cmd_rd_size = rs; cmd_wr_size = ws;
    cmd_rd_inc = ri; cmd_wr_inc = wi; cmd_cont = ct; cmd_len = LEN_W'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    seen_done = 0; seen_err = 0; cyc = 0;
    while (!done && !err && cyc < 2000) begin
      if (inject && cyc == 2) begin
        cmd_rd_size = 2'b11; cmd_wr_addr = 32'hC0; cmd_cont = 1'b0; cmd_valid = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    seen_done = done; seen_err = err;
    if (reject) begin
      check(seen_err && !seen_done, (rb == 0 || wb == 0) ? "R2" : "R7",
            "reject pulse", {seen_err, seen_done}, 2'b10);
      check(nrd == 0 && nwr == 0, (rb == 0 || wb == 0) ? "R2" : "R7",
            "accesses on rejected command", nrd + nwr, 0);
    end else begin
      check(seen_done && !seen_err, inject ? "R11" : (len == 0 ? "R8" : "R10"),
            "done pulse", {seen_err, seen_done}, 2'b01);
      check(!busy && !bus_req, "R10", "idle at done", {busy, bus_req}, 0);
      check(nrd == len / rb && nwr == len / wb, len == 0 ? "R8" : "R9",
            "access counts", nrd * 1000 + nwr, (len / rb) * 1000 + len / wb);
      for (int i = 0; i < 256; i++) begin
        if (dst[i] !== expd[i]) begin
          check(0, inject ? "R11" : (ct ? "R6" : "R3"), $sformatf("dst byte %0d", i),
                dst[i], expd[i]);
          break;
        end
      end
      vectors++;
      if (len != 0) begin
        pa_r = rstart + 32'(ri ? len : 0);
        pa_w = wstart + 32'(wi ? len : 0);
      end
    end
    @(negedge clk);
    check(!done, "R10", "done is one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pa_r = '0; pa_w = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !bus_req, "R10", "reset state",
          {busy, done, err, bus_req}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3: all nine size pairs, both sides stepping
    for (int r = 0; r < 3; r++)
      for (int w = 0; w < 3; w++)
        run_move(2'(r), 2'(w), 1, 1, 0, 16, 32'h10, 32'h80, 0);
    // R4: fixed read address (FIFO source)
    run_move(2'b10, 2'b00, 0, 1, 0, 12, 32'h24, 32'h40, 0);
    run_move(2'b00, 2'b10, 0, 1, 0, 8, 32'h33, 32'h60, 0);
    // R5: fixed write address
    run_move(2'b00, 2'b01, 1, 0, 0, 10, 32'h08, 32'hA0, 0);
    // R6: continue chain, new addresses ignored
    run_move(2'b01, 2'b10, 1, 1, 0, 8, 32'h20, 32'h90, 0);
    run_move(2'b01, 2'b10, 1, 1, 1, 8, 32'hF0, 32'hF0, 0);
    run_move(2'b10, 2'b01, 1, 1, 1, 4, 32'h00, 32'h00, 0);
    // R8: zero length
    run_move(2'b10, 2'b10, 1, 1, 0, 0, 32'h0, 32'h0, 0);
    // R2: reserved codes on each side
    run_move(2'b11, 2'b00, 1, 1, 0, 4, 32'h0, 32'h40, 0);
    run_move(2'b00, 2'b11, 1, 1, 0, 4, 32'h0, 32'h40, 0);
    // R7: length not a multiple of the larger size
    run_move(2'b00, 2'b10, 1, 1, 0, 6, 32'h0, 32'h40, 0);
    run_move(2'b01, 2'b00, 1, 1, 0, 3, 32'h0, 32'h40, 0);
    // R6: continue after a rejection keeps the previous end addresses
    run_move(2'b00, 2'b00, 1, 1, 1, 4, 32'h0, 32'h0, 0);
    // R11: strobe while busy
    run_move(2'b00, 2'b01, 1, 1, 0, 12, 32'h50, 32'h70, 1);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0] rs, ws;
      int ch, len;
      bit ct;
      rs = 2'($urandom % 3);
      ws = 2'($urandom % 3);
      if (($urandom % 10) == 0) rs = 2'b11;
      ch = (nbytes(rs) > nbytes(ws)) ? nbytes(rs) : nbytes(ws);
      len = (ch == 0) ? 4 : ch * int'($urandom % 7);
      if (($urandom % 8) == 0) len = len + 1;
      ct = (($urandom % 4) == 0) && (pa_r < 32'h80) && (pa_w < 32'h80);
      run_move(rs, ws, 1'($urandom), 1'($urandom), ct, len,
               32'(($urandom % 32) * 4), 32'(($urandom % 32) * 4), 0);
    end
    finish_run();
  end
endmodule